// File: doc/BRIEF.md
# Adaptive Diagnostic Tree Sequencer

This block steers a fault-diagnosis run by walking a fixed binary decision tree. After a start pulse it requests one test at a time from an external test applier. It holds that request until a result comes back, then picks the next test from the pass/fail outcome. When a branch ends in a leaf, it reports the fault class in a one-cycle done pulse. Because each choice depends on earlier outcomes, a run applies two to four tests instead of the whole set.

The tree has four tests and seven leaves. The root test is T4. If T4 fails, T2 separates the stuck-low group {a0,b0,d0} from e0. If T4 passes, T1 follows. A T1 failure leads to T3, which separates a1 from the group {c1,d1,e1}. A T1 pass leads to T2, where a failure means c0. If T2 also passes, T3 decides between no fault found and b1.

Top module: `diag_tree_seq`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, req_valid_o and done_o are low and leaf_o is 0.
- R2: A start_i pulse while idle raises req_valid_o in the next cycle with req_test_o = 3 (T4). Tests are coded T1=0, T2=1, T3=2, T4=3.
- R3: Once raised, req_valid_o and req_test_o stay unchanged until a cycle in which res_valid_i is high. That cycle's res_fail_i (1 = fail) is taken as the result.
- R4: After T4 fails, T2 is requested. A T2 pass ends with leaf 4 ({a0,b0,d0}); a T2 fail ends with leaf 5 (e0).
- R5: After T4 passes, T1 is requested. If T1 fails, T3 follows: a T3 pass ends with leaf 2 (a1), a T3 fail with leaf 3 ({c1,d1,e1}).
- R6: After T4 and T1 pass, T2 is requested. A T2 fail ends with leaf 6 (c0).
- R7: After T4, T1 and T2 pass, T3 is requested. A T3 pass ends with leaf 0 (no fault found), a T3 fail with leaf 1 (b1).
- R8: A leaf is reported by done_o high for exactly one cycle, the cycle after the deciding result, with leaf_o holding the code. leaf_o is 0 whenever done_o is low. The cycle after done has no request, and done_o and req_valid_o are never high together.
- R9: start_i is ignored while a run is in progress. res_valid_i is ignored while no test is requested.
- R10: A result that does not end the run is followed, in the next cycle, by the request for the next test on that branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a diagnosis run (honoured only when idle) |
| req_valid_o | output | 1 | A test is being requested |
| req_test_o | output | 2 | Requested test number (T1=0 .. T4=3) |
| res_valid_i | input | 1 | Result strobe for the requested test |
| res_fail_i | input | 1 | Result of the test, 1 = fail |
| done_o | output | 1 | One-cycle pulse marking the end of a run |
| leaf_o | output | 3 | Fault class code, valid with done_o |

## Verification
The bench walks all sixteen result patterns and more random ones. It answers after random delays, so a design that dropped or changed its request before the strobe is caught. Stray start pulses are sent mid-run, which catches a design that restarts at the root. A result strobe is sent while idle, which catches a design that wanders into the tree without a start. The paths that differ only in the last outcome (T2 on the T4-fail side, the final T3 on each pass side) expose swapped leaf codes. The T1-pass/T2-fail exit catches a design that carries on to T3 instead of stopping at c0.

// File: rtl/diag_seq_pkg.sv
package diag_seq_pkg;
  localparam int TEST_W = 2;
  localparam int LEAF_W = 3;
  localparam int NODE_W = 3;

  localparam logic [TEST_W-1:0] TEST_T1 = 2'd0;
  localparam logic [TEST_W-1:0] TEST_T2 = 2'd1;
  localparam logic [TEST_W-1:0] TEST_T3 = 2'd2;
  localparam logic [TEST_W-1:0] TEST_T4 = 2'd3;

  localparam logic [LEAF_W-1:0] LEAF_CLEAN   = 3'd0;
  localparam logic [LEAF_W-1:0] LEAF_B_HI    = 3'd1;
  localparam logic [LEAF_W-1:0] LEAF_A_HI    = 3'd2;
  localparam logic [LEAF_W-1:0] LEAF_CDE_HI  = 3'd3;
  localparam logic [LEAF_W-1:0] LEAF_ABD_LO  = 3'd4;
  localparam logic [LEAF_W-1:0] LEAF_E_LO    = 3'd5;
  localparam logic [LEAF_W-1:0] LEAF_C_LO    = 3'd6;
  localparam logic [LEAF_W-1:0] LEAF_MAX     = LEAF_C_LO;

  typedef enum logic [NODE_W-1:0] {
    ND_IDLE,
    ND_ROOT,
    ND_LO_T2,
    ND_HI_T1,
    ND_HI_T3A,
    ND_HI_T2,
    ND_HI_T3B,
    ND_DONE
  } node_e;

  typedef struct packed {
    logic                is_leaf;
    node_e               node;
    logic [LEAF_W-1:0]   leaf;
  } branch_t;
endpackage

// File: rtl/diag_node_table.sv
module diag_node_table
  import diag_seq_pkg::*;
(
  input  node_e             node_i,
  output logic              is_test_o,
  output logic [TEST_W-1:0] test_o,
  output branch_t           on_pass_o,
  output branch_t           on_fail_o
);
  function automatic branch_t go_node(input node_e n);
    go_node = '{is_leaf: 1'b0, node: n, leaf: '0};
  endfunction

  function automatic branch_t go_leaf(input logic [LEAF_W-1:0] l);
    go_leaf = '{is_leaf: 1'b1, node: ND_DONE, leaf: l};
  endfunction

  always_comb begin
    is_test_o = 1'b1;
    test_o    = TEST_T4;
    on_pass_o = go_node(ND_IDLE);
    on_fail_o = go_node(ND_IDLE);
    unique case (node_i)
      ND_ROOT: begin
        test_o    = TEST_T4;
        on_pass_o = go_node(ND_HI_T1);
        on_fail_o = go_node(ND_LO_T2);
      end
      ND_LO_T2: begin
        test_o    = TEST_T2;
        on_pass_o = go_leaf(LEAF_ABD_LO);
        on_fail_o = go_leaf(LEAF_E_LO);
      end
      ND_HI_T1: begin
        test_o    = TEST_T1;
        on_pass_o = go_node(ND_HI_T2);
        on_fail_o = go_node(ND_HI_T3A);
      end
      ND_HI_T3A: begin
        test_o    = TEST_T3;
        on_pass_o = go_leaf(LEAF_A_HI);
        on_fail_o = go_leaf(LEAF_CDE_HI);
      end
      ND_HI_T2: begin
        test_o    = TEST_T2;
        on_pass_o = go_node(ND_HI_T3B);
        on_fail_o = go_leaf(LEAF_C_LO);
      end
      ND_HI_T3B: begin
        test_o    = TEST_T3;
        on_pass_o = go_leaf(LEAF_CLEAN);
        on_fail_o = go_leaf(LEAF_B_HI);
      end
      default: begin
        is_test_o = 1'b0;
        test_o    = '0;
      end
    endcase
  end
endmodule

// File: rtl/diag_seq_ctrl.sv
module diag_seq_ctrl
  import diag_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              res_valid_i,
  input  logic              res_fail_i,
  input  branch_t           on_pass_i,
  input  branch_t           on_fail_i,
  output node_e             node_o,
  output logic              done_o,
  output logic [LEAF_W-1:0] leaf_o
);
  node_e             node_q, node_d;
  logic [LEAF_W-1:0] leaf_q, leaf_d;
  logic              leaf_en;
  branch_t           taken;

  always_comb begin
    node_d  = node_q;
    leaf_d  = leaf_q;
    leaf_en = 1'b0;
    taken   = res_fail_i ? on_fail_i : on_pass_i;
    unique case (node_q)
      ND_IDLE: if (start_i) node_d = ND_ROOT;
      ND_DONE: node_d = ND_IDLE;
      default: begin
        if (res_valid_i) begin
          if (taken.is_leaf) begin
            node_d  = ND_DONE;
            leaf_en = 1'b1;
            leaf_d  = taken.leaf;
          end else begin
            node_d = taken.node;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) node_q <= ND_IDLE;
    else        node_q <= node_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       leaf_q <= '0;
    else if (leaf_en) leaf_q <= leaf_d;
  end

  assign node_o = node_q;
  assign done_o = (node_q == ND_DONE);
  assign leaf_o = done_o ? leaf_q : '0;
endmodule

// File: rtl/diag_tree_seq.sv
module diag_tree_seq
  import diag_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              req_valid_o,
  output logic [TEST_W-1:0] req_test_o,
  input  logic              res_valid_i,
  input  logic              res_fail_i,
  output logic              done_o,
  output logic [LEAF_W-1:0] leaf_o
);
  node_e   node_q;
  branch_t on_pass, on_fail;
  logic    is_test;

  diag_node_table table_i (
    .node_i    (node_q),
    .is_test_o (is_test),
    .test_o    (req_test_o),
    .on_pass_o (on_pass),
    .on_fail_o (on_fail)
  );

  diag_seq_ctrl ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .res_valid_i (res_valid_i),
    .res_fail_i  (res_fail_i),
    .on_pass_i   (on_pass),
    .on_fail_i   (on_fail),
    .node_o      (node_q),
    .done_o      (done_o),
    .leaf_o      (leaf_o)
  );

  assign req_valid_o = is_test;
endmodule

// File: rtl/diag_tree_seq_chk.sv
module diag_tree_seq_chk
  import diag_seq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              req_valid_o,
  input logic [TEST_W-1:0] req_test_o,
  input logic              res_valid_i,
  input logic              res_fail_i,
  input logic              done_o,
  input logic [LEAF_W-1:0] leaf_o,
  input node_e             node_q
);
  // R2
  start_root_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (node_q == ND_IDLE && start_i) |=> (req_valid_o && req_test_o == TEST_T4));

  // R3
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !res_valid_i) |=> (req_valid_o && $stable(req_test_o)));

  // R4
  root_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && req_test_o == TEST_T4 && res_valid_i && res_fail_i)
      |=> (req_valid_o && req_test_o == TEST_T2));

  // R5
  root_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && req_test_o == TEST_T4 && res_valid_i && !res_fail_i)
      |=> (req_valid_o && req_test_o == TEST_T1));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !req_valid_o));

  // R8
  leaf_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> (leaf_o == '0));

  // R8
  excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && req_valid_o));

  // R8
  leaf_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (leaf_o <= LEAF_MAX));

  // R9
  idle_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid_o && !done_o && !start_i) |=> !req_valid_o);

  // R10
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && res_valid_i) |=> (req_valid_o ^ done_o));
endmodule

bind diag_tree_seq diag_tree_seq_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .req_valid_o (req_valid_o),
  .req_test_o  (req_test_o),
  .res_valid_i (res_valid_i),
  .res_fail_i  (res_fail_i),
  .done_o      (done_o),
  .leaf_o      (leaf_o),
  .node_q      (node_q)
);

// File: tb/diag_tree_seq_tb_top.sv
module diag_tree_seq_tb_top;
  logic       clk;
  logic       rst_n;
  logic       start_i;
  logic       req_valid_o;
  logic [1:0] req_test_o;
  logic       res_valid_i;
  logic       res_fail_i;
  logic       done_o;
  logic [2:0] leaf_o;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;
  bit finished = 0;

  diag_tree_seq dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .req_valid_o (req_valid_o),
    .req_test_o  (req_test_o),
    .res_valid_i (res_valid_i),
    .res_fail_i  (res_fail_i),
    .done_o      (done_o),
    .leaf_o      (leaf_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // syndrome bit i = 1 means test with code i fails (T1=0 .. T4=3)
  function automatic int exp_len(input logic [3:0] s);
    if (s[3]) return 2;
    if (s[0] || s[1]) return 3;
    return 4;
  endfunction

  function automatic int exp_test(input logic [3:0] s, input int k);
    if (s[3]) return (k == 0) ? 3 : 1;
    case (k)
      0: return 3;
      1: return 0;
      2: return s[0] ? 2 : 1;
      default: return 2;
    endcase
  endfunction

  function automatic int exp_leaf(input logic [3:0] s);
    if (s[3]) return s[1] ? 5 : 4;
    if (s[0]) return s[2] ? 3 : 2;
    if (s[1]) return 6;
    return s[2] ? 1 : 0;
  endfunction

  function automatic string branch_tag(input logic [3:0] s);
    if (s[3]) return "R4";
    if (s[0]) return "R5";
    if (s[1]) return "R6";
    return "R7";
  endfunction

  task automatic run_session(input logic [3:0] s, input bit noisy);
    int n;
    string tag;
    n   = exp_len(s);
    tag = branch_tag(s);
    // stray result while idle must do nothing (R9)
    if (noisy) begin
      res_valid_i = 1'b1;
      res_fail_i  = 1'($urandom_range(0, 1));
      @(negedge clk);
      res_valid_i = 1'b0;
      check(!req_valid_o && !done_o, "R9 idle result ignored", int'(req_valid_o), 0);
    end
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(req_valid_o && req_test_o == 2'd3, "R2 root test", int'(req_test_o), 3);
    for (int k = 0; k < n; k++) begin
      int et;
      int d;
      et = exp_test(s, k);
      check(req_valid_o && int'(req_test_o) == et,
            (k == 0) ? "R2 root" : ((k == 1) ? "R10 next test" : tag),
            int'(req_test_o), et);
      d = $urandom_range(0, 3);
      for (int w = 0; w < d; w++) begin
        start_i = noisy;
        @(negedge clk);
        start_i = 1'b0;
        check(req_valid_o && int'(req_test_o) == et, "R3 R9 request held",
              int'(req_test_o), et);
      end
      res_valid_i = 1'b1;
      res_fail_i  = s[et];
      @(negedge clk);
      res_valid_i = 1'b0;
      res_fail_i  = 1'b0;
      if (k < n - 1)
        check(req_valid_o && !done_o, "R10 continue", int'(req_valid_o), 1);
    end
    check(done_o && !req_valid_o, "R8 done pulse", int'(done_o), 1);
    check(int'(leaf_o) == exp_leaf(s), tag, int'(leaf_o), exp_leaf(s));
    @(negedge clk);
    check(!done_o && !req_valid_o && leaf_o == 3'd0, "R8 one cycle done",
          int'(done_o), 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n       = 1'b0;
    start_i     = 1'b0;
    res_valid_i = 1'b0;
    res_fail_i  = 1'b0;
    repeat (3) @(negedge clk);
    check(!req_valid_o && !done_o && leaf_o == 3'd0, "R1 in reset", int'(req_valid_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!req_valid_o && !done_o && leaf_o == 3'd0, "R1 after reset", int'(done_o), 0);
    for (int s = 0; s < 16; s++) run_session(4'(s), 1'b0);
    for (int s = 0; s < 16; s++) run_session(4'(s), 1'b1);
    for (int r = 0; r < 60; r++) run_session(4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)));
    // reset in mid-run
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check(!req_valid_o && !done_o, "R1 reset mid-run", int'(req_valid_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!req_valid_o && !done_o, "R1 idle after reset", int'(req_valid_o), 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule